// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block decides which clocks of a microcontroller run while the core sleeps. It has two sleep states. In the deep state the oscillator and every derived clock are shut off. In the light state the oscillator keeps running and only the CPU bus clock and the watchdog clock are gated. Software enters the deep state by setting a stop request bit in a clock control register. The CPU enters the light state by pulsing a wait strobe.

The block leaves either state on a qualified wake event. A maskable interrupt wakes it only if that interrupt is enabled and has a nonzero priority level. A non-maskable interrupt always wakes it, and so does reset. After the deep state the CPU clock stays off for a programmable number of oscillator cycles, so that the oscillator can settle. A one-cycle wake pulse marks the cycle in which the CPU clock returns.

The block also owns the main clock divider select bit of the system clock register. It sets that bit on reset, on entry to the deep state from a fast speed mode, and when the speed mode changes to low-power.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: After reset all six clock enables are 1 and wakePulse is 0. sysRegQ reads 0x40 (divider select, bit 6, set) and clkRegQ reads 0x00.
- R2: A write of a value with bit 0 set to address 0x07 while running sets clkRegQ bit 0. From the second rising edge after the write cycle, oscEn, cpuClkEn, wdtClkEn, perClkEn, subClkEn and adcClkEn are all 0.
- R3: A waitStrobe cycle while running makes cpuClkEn and wdtClkEn 0 from the next edge, while oscEn and subClkEn stay 1. perClkEn and adcClkEn stay 1 while bit 2 of register 0x07 is 0.
- R4: In the light state with bit 2 of register 0x07 set, perClkEn and adcClkEn are 0 when speedMode is 00 (high) or 01 (medium). They stay 1 when speedMode is 10 (low) or 11 (low-power).
- R5: An irqReq wakes the block only when irqEnable is 1 and irqLevel is nonzero. Otherwise the sleep state and its enables are unchanged.
- R6: nmiReq wakes the block from either sleep state, whatever irqEnable and irqLevel are.
- R7: A wake event in the light state restores cpuClkEn at the next edge, with wakePulse high for exactly that one cycle.
- R8: A wake event in the deep state turns oscEn on at the next edge. cpuClkEn then stays 0 for max(1, stabCycles) cycles, and rises together with a one-cycle wakePulse.
- R9: The stop request bit (clkRegQ bit 0) reads 0 once the deep state has been left.
- R10: Entering the deep state sets the divider select bit when speedMode is 00 or 01, and leaves it unchanged when speedMode is 10 or 11.
- R11: A change of speedMode to 11 from another value sets the divider select bit. A change to 10 leaves it unchanged.
- R12: The divider select bit keeps its value across a light-state sleep and an interrupt wake.
- R13: Writes to address 0x06 load sysRegQ, with divSel equal to bit 6. Writes to any address other than 0x06 and 0x07 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address (0x06 system, 0x07 clock control) |
| wrData | input | 8 | Register write data |
| waitStrobe | input | 1 | One-cycle pulse from the CPU's wait instruction |
| irqReq | input | 1 | Maskable interrupt request |
| irqEnable | input | 1 | Enable of that interrupt |
| irqLevel | input | 3 | Priority level of that interrupt; 0 never wakes |
| nmiReq | input | 1 | Non-maskable interrupt |
| speedMode | input | 2 | 00 high, 01 medium, 10 low, 11 low-power |
| stabCycles | input | 16 | Oscillator settle count after the deep state |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU bus clock enable |
| wdtClkEn | output | 1 | Watchdog clock enable |
| perClkEn | output | 1 | Divided peripheral clock group enable |
| subClkEn | output | 1 | Low-speed sub-clock enable |
| adcClkEn | output | 1 | Converter clock enable |
| divSel | output | 1 | Main clock divider select bit |
| wakePulse | output | 1 | One-cycle pulse when the CPU clock resumes |
| sysRegQ | output | 8 | Readback of register 0x06 |
| clkRegQ | output | 8 | Readback of register 0x07 |

## Verification
The hardest case to reach is a set of wake inputs that are present but not qualified: an interrupt that is requested but disabled, one that is enabled at level zero, or an NMI together with a level-zero interrupt. Each has to be applied while the block is already asleep, under each speed mode and peripheral-stop setting. A vector table handles this. Each entry programs the peripheral-stop bit, puts the block into the light state, checks the gating, applies one wake pattern for a single cycle, and forces an NMI release whenever no wake is expected. Directed sequences then cover the settle countdown after the deep state and the divider bit across speed-mode changes.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    SPD_HIGH = 2'b00,
    SPD_MED  = 2'b01,
    SPD_LOW  = 2'b10,
    SPD_LPWR = 2'b11
  } speed_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_WAIT,
    ST_STOP,
    ST_STAB
  } pmState_e;

  typedef struct packed {
    logic enterStop;
    logic stopWake;
    logic stabTick;
  } ctlStrobe_t;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int          DataW      = 8,
  parameter int          AddrW      = 8,
  parameter int          CntW       = 16,
  parameter logic [7:0]  SysAddr    = 8'h06,
  parameter logic [7:0]  ClkAddr    = 8'h07,
  parameter int          StopBit    = 0,
  parameter int          WaitPerBit = 2,
  parameter int          DivBit     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  input  speed_e           speedMode,
  input  logic [CntW-1:0]  stabCycles,
  input  ctlStrobe_t       stb,
  output logic [DataW-1:0] sysReg,
  output logic [DataW-1:0] clkReg,
  output logic             stopReq,
  output logic             waitPerStop,
  output logic             stabDone
);

  localparam logic [DataW-1:0] SysReset = DataW'(1) << DivBit;
  localparam logic [AddrW-1:0] SysA     = AddrW'(SysAddr);
  localparam logic [AddrW-1:0] ClkA     = AddrW'(ClkAddr);
  localparam logic [CntW-1:0]  CntOne   = CntW'(1);

  speed_e           prevSpeed;
  logic [CntW-1:0]  stabCnt;
  logic [DataW-1:0] sysNext, clkNext;
  logic             fastMode, lpEntry, forceDiv;

  assign fastMode = (speedMode == SPD_HIGH) || (speedMode == SPD_MED);
  assign lpEntry  = (speedMode == SPD_LPWR) && (prevSpeed != SPD_LPWR);
  assign forceDiv = (stb.enterStop && fastMode) || lpEntry;

  always_comb begin
    sysNext = sysReg;
    if (wrEn && wrAddr == SysA) sysNext = wrData;
    if (forceDiv) sysNext[DivBit] = 1'b1;
  end

  always_comb begin
    clkNext = clkReg;
    if (wrEn && wrAddr == ClkA) clkNext = wrData;
    if (stb.stopWake) clkNext[StopBit] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysReg    <= SysReset;
      clkReg    <= '0;
      prevSpeed <= SPD_HIGH;
      stabCnt   <= '0;
    end else begin
      sysReg    <= sysNext;
      clkReg    <= clkNext;
      prevSpeed <= speedMode;
      if (stb.stopWake)      stabCnt <= stabCycles;
      else if (stb.stabTick) stabCnt <= stabCnt - CntOne;
    end
  end

  assign stopReq     = clkReg[StopBit];
  assign waitPerStop = clkReg[WaitPerBit];
  assign stabDone    = (stabCnt <= CntOne);

  // R10
  divsel_stop_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enterStop && fastMode) |=> sysReg[DivBit]);

  // R9
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stopWake |=> !clkReg[StopBit]);

  // R11
  divsel_lp_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((speedMode == SPD_LPWR) && (prevSpeed != SPD_LPWR)) |=> sysReg[DivBit]);

endmodule

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
#(
  parameter int LevelW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              waitStrobe,
  input  logic              irqReq,
  input  logic              irqEnable,
  input  logic [LevelW-1:0] irqLevel,
  input  logic              nmiReq,
  input  speed_e            speedMode,
  input  logic              stopReq,
  input  logic              waitPerStop,
  input  logic              stabDone,
  output ctlStrobe_t        stb,
  output logic              oscEn,
  output logic              cpuClkEn,
  output logic              wdtClkEn,
  output logic              perClkEn,
  output logic              subClkEn,
  output logic              adcClkEn,
  output logic              wakePulse
);

  pmState_e state, stateNext;
  logic     wakeOk, resumeNow, slowMode, perGate;

  assign wakeOk   = nmiReq || (irqReq && irqEnable && (irqLevel != '0));
  assign slowMode = (speedMode == SPD_LOW) || (speedMode == SPD_LPWR);
  assign perGate  = waitPerStop && !slowMode;

  always_comb begin
    stateNext = state;
    stb       = '0;
    resumeNow = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (stopReq) begin
          stateNext     = ST_STOP;
          stb.enterStop = 1'b1;
        end else if (waitStrobe) begin
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wakeOk) begin
          stateNext = ST_RUN;
          resumeNow = 1'b1;
        end
      end
      ST_STOP: begin
        if (wakeOk) begin
          stateNext    = ST_STAB;
          stb.stopWake = 1'b1;
        end
      end
      ST_STAB: begin
        if (stabDone) begin
          stateNext = ST_RUN;
          resumeNow = 1'b1;
        end else begin
          stb.stabTick = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      wakePulse <= 1'b0;
    end else begin
      state     <= stateNext;
      wakePulse <= resumeNow;
    end
  end

  always_comb begin
    oscEn    = 1'b1;
    cpuClkEn = 1'b1;
    wdtClkEn = 1'b1;
    perClkEn = 1'b1;
    subClkEn = 1'b1;
    adcClkEn = 1'b1;
    unique case (state)
      ST_RUN: ;
      ST_WAIT: begin
        cpuClkEn = 1'b0;
        wdtClkEn = 1'b0;
        perClkEn = !perGate;
        adcClkEn = !perGate;
      end
      ST_STOP: begin
        oscEn    = 1'b0;
        cpuClkEn = 1'b0;
        wdtClkEn = 1'b0;
        perClkEn = 1'b0;
        subClkEn = 1'b0;
        adcClkEn = 1'b0;
      end
      ST_STAB: begin
        cpuClkEn = 1'b0;
        wdtClkEn = 1'b0;
        perClkEn = 1'b0;
        subClkEn = 1'b0;
        adcClkEn = 1'b0;
      end
      default: ;
    endcase
  end

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R8
  pulse_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (cpuClkEn && !$past(cpuClkEn)));

  // R5
  nowake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && !nmiReq && !(irqReq && irqEnable && (irqLevel != '0)))
      |=> !cpuClkEn);

  // R2
  osc_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!cpuClkEn && !subClkEn && !perClkEn && !adcClkEn));

  // R3
  wait_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && wdtClkEn) |-> 1'b0);

endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
  import lpm_pkg::*;
#(
  parameter int CntW   = 16,
  parameter int LevelW = 3,
  parameter int DataW  = 8,
  parameter int AddrW  = 8,
  parameter int DivBit = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AddrW-1:0]  wrAddr,
  input  logic [DataW-1:0]  wrData,
  input  logic              waitStrobe,
  input  logic              irqReq,
  input  logic              irqEnable,
  input  logic [LevelW-1:0] irqLevel,
  input  logic              nmiReq,
  input  logic [1:0]        speedMode,
  input  logic [CntW-1:0]   stabCycles,
  output logic              oscEn,
  output logic              cpuClkEn,
  output logic              wdtClkEn,
  output logic              perClkEn,
  output logic              subClkEn,
  output logic              adcClkEn,
  output logic              divSel,
  output logic              wakePulse,
  output logic [DataW-1:0]  sysRegQ,
  output logic [DataW-1:0]  clkRegQ
);

  ctlStrobe_t stb;
  speed_e     speedE;
  logic       stopReq, waitPerStop, stabDone;

  assign speedE = speed_e'(speedMode);

  lpm_datapath #(
    .DataW  (DataW),
    .AddrW  (AddrW),
    .CntW   (CntW),
    .DivBit (DivBit)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .speedMode   (speedE),
    .stabCycles  (stabCycles),
    .stb         (stb),
    .sysReg      (sysRegQ),
    .clkReg      (clkRegQ),
    .stopReq     (stopReq),
    .waitPerStop (waitPerStop),
    .stabDone    (stabDone)
  );

  lpm_control #(
    .LevelW (LevelW)
  ) uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .waitStrobe  (waitStrobe),
    .irqReq      (irqReq),
    .irqEnable   (irqEnable),
    .irqLevel    (irqLevel),
    .nmiReq      (nmiReq),
    .speedMode   (speedE),
    .stopReq     (stopReq),
    .waitPerStop (waitPerStop),
    .stabDone    (stabDone),
    .stb         (stb),
    .oscEn       (oscEn),
    .cpuClkEn    (cpuClkEn),
    .wdtClkEn    (wdtClkEn),
    .perClkEn    (perClkEn),
    .subClkEn    (subClkEn),
    .adcClkEn    (adcClkEn),
    .wakePulse   (wakePulse)
  );

  assign divSel = sysRegQ[DivBit];

endmodule

// File: tb/tb_lpm_clock_ctrl.sv
module tb_lpm_clock_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        waitStrobe = 1'b0;
  logic        irqReq = 1'b0;
  logic        irqEnable = 1'b0;
  logic [2:0]  irqLevel = '0;
  logic        nmiReq = 1'b0;
  logic [1:0]  speedMode = 2'b00;
  logic [15:0] stabCycles = 16'd1;
  logic        oscEn, cpuClkEn, wdtClkEn, perClkEn, subClkEn, adcClkEn;
  logic        divSel, wakePulse;
  logic [7:0]  sysRegQ, clkRegQ;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lpm_clock_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .waitStrobe(waitStrobe), .irqReq(irqReq), .irqEnable(irqEnable),
    .irqLevel(irqLevel), .nmiReq(nmiReq), .speedMode(speedMode),
    .stabCycles(stabCycles), .oscEn(oscEn), .cpuClkEn(cpuClkEn),
    .wdtClkEn(wdtClkEn), .perClkEn(perClkEn), .subClkEn(subClkEn),
    .adcClkEn(adcClkEn), .divSel(divSel), .wakePulse(wakePulse),
    .sysRegQ(sysRegQ), .clkRegQ(clkRegQ)
  );

  // {speed[10:9], waitBit[8], irq[7], en[6], lvl[5:3], nmi[2], expPer[1], expWake[0]}
  localparam logic [10:0] VEC [0:7] = '{
    11'b00_0_1_1_011_0_1_1,
    11'b00_1_1_1_001_0_0_1,
    11'b01_1_1_0_101_0_0_0,
    11'b10_1_1_1_000_0_1_0,
    11'b11_1_0_0_000_1_1_1,
    11'b01_0_1_1_000_1_1_1,
    11'b00_1_0_1_111_0_0_0,
    11'b10_0_1_1_010_0_1_1
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic enterWait();
    waitStrobe = 1'b1;
    @(negedge clk);
    waitStrobe = 1'b0;
  endtask

  task automatic nmiRelease();
    nmiReq = 1'b1;
    @(negedge clk);
    nmiReq = 1'b0;
  endtask

  function automatic logic [5:0] enables();
    return {oscEn, cpuClkEn, wdtClkEn, perClkEn, subClkEn, adcClkEn};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 enables", 16'(enables()), 16'h3F);
    check("R1 wakePulse", 16'(wakePulse), 16'h0);
    check("R1 sysRegQ", 16'(sysRegQ), 16'h40);
    check("R1 clkRegQ", 16'(clkRegQ), 16'h00);

    // R3 R4 R5 R6 R7 vector table
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      speedMode = v[10:9];
      regWrite(8'h07, {5'b0, v[8], 2'b00});
      enterWait();
      check("R3 osc/sub in wait", 16'({oscEn, subClkEn}), 16'h3);
      check("R3 cpu/wdt off in wait", 16'({cpuClkEn, wdtClkEn}), 16'h0);
      check("R4 per/adc gating", 16'({perClkEn, adcClkEn}), {14'b0, v[1], v[1]});
      irqReq = v[7]; irqEnable = v[6]; irqLevel = v[5:3]; nmiReq = v[2];
      @(negedge clk);
      irqReq = 1'b0; irqEnable = 1'b0; irqLevel = '0; nmiReq = 1'b0;
      check("R5 R6 wake qualification cpu", 16'(cpuClkEn), 16'(v[0]));
      check("R7 wake pulse", 16'(wakePulse), 16'(v[0]));
      if (v[0]) begin
        @(negedge clk);
        check("R7 pulse one cycle", 16'(wakePulse), 16'h0);
      end else begin
        check("R5 state held", 16'(wdtClkEn), 16'h0);
        nmiRelease();
        check("R6 nmi release", 16'(cpuClkEn), 16'h1);
        @(negedge clk);
      end
    end

    // R13 register writes
    speedMode = 2'b00;
    @(negedge clk);
    regWrite(8'h07, 8'h00);
    regWrite(8'h06, 8'h5A);
    check("R13 sys write", 16'(sysRegQ), 16'h5A);
    check("R13 divSel bit6", 16'(divSel), 16'h1);
    regWrite(8'h06, 8'h00);
    regWrite(8'h05, 8'hFF);
    check("R13 other addr sys", 16'(sysRegQ), 16'h00);
    check("R13 other addr clk", 16'(clkRegQ), 16'h00);

    // R2 R10 stop from high speed
    regWrite(8'h07, 8'h01);
    check("R2 stop bit set", 16'(clkRegQ[0]), 16'h1);
    check("R2 still running", 16'(cpuClkEn), 16'h1);
    @(negedge clk);
    check("R2 all enables off", 16'(enables()), 16'h00);
    check("R10 divSel forced", 16'(divSel), 16'h1);

    // R8 stabilisation count 5
    stabCycles = 16'd5;
    nmiRelease();
    check("R8 osc on", 16'(oscEn), 16'h1);
    check("R8 cpu held", 16'(cpuClkEn), 16'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 cpu held", 16'(cpuClkEn), 16'h0);
    end
    @(negedge clk);
    check("R8 cpu resumes", 16'(cpuClkEn), 16'h1);
    check("R8 wake pulse", 16'(wakePulse), 16'h1);
    check("R9 stop bit cleared", 16'(clkRegQ[0]), 16'h0);
    @(negedge clk);
    check("R8 pulse one cycle", 16'(wakePulse), 16'h0);

    // R10 stop from low speed keeps divSel, R8 with count 0
    regWrite(8'h06, 8'h00);
    speedMode = 2'b10;
    @(negedge clk);
    regWrite(8'h07, 8'h01);
    @(negedge clk);
    check("R10 divSel kept", 16'(divSel), 16'h0);
    stabCycles = 16'd0;
    nmiRelease();
    check("R8 zero count one cycle held", 16'(cpuClkEn), 16'h0);
    @(negedge clk);
    check("R8 zero count resumes", 16'(cpuClkEn), 16'h1);
    check("R9 stop bit cleared", 16'(clkRegQ[0]), 16'h0);

    // R11 speed changes
    speedMode = 2'b11;
    @(negedge clk);
    check("R11 lp entry forces", 16'(divSel), 16'h1);
    speedMode = 2'b00;
    @(negedge clk);
    regWrite(8'h06, 8'h00);
    speedMode = 2'b10;
    @(negedge clk);
    check("R11 low entry keeps", 16'(divSel), 16'h0);

    // R12 divider across wait
    speedMode = 2'b00;
    @(negedge clk);
    enterWait();
    irqReq = 1'b1; irqEnable = 1'b1; irqLevel = 3'd4;
    @(negedge clk);
    irqReq = 1'b0; irqEnable = 1'b0; irqLevel = '0;
    check("R12 resumed", 16'(cpuClkEn), 16'h1);
    check("R12 divSel kept", 16'(divSel), 16'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule